// File: doc/BRIEF.md
# SPI Serial-Flash Command Front-End

This block sits on the device side of a serial NOR flash and turns the four pin signals (serial clock, active-low select, serial in, serial out) into requests for the flash array controller. After select goes low it gathers an eight-bit command code, most significant bit first, on rising serial-clock edges. Depending on that code it then collects a 24-bit address, skips filler bytes, and either accepts data bytes or streams read bytes back. The array, its status and signature values, and all program and erase timing sit behind a plain request port and are not part of the block.

Commands that change the device (write enable and disable, status write, page program, sector and whole-array erase, power-down, wake) are only carried out when select rises after a whole number of bytes. The block then issues one execute strobe that carries the command code and address. Read-type commands stream bytes until select rises and may be cut short at any bit. The serial pins are sampled by the block clock `clk`, so the serial clock must run at least eight times slower than `clk`. The pins are assumed to be synchronised before they reach the block.

The controller has eight states. IDLE is the state while deselected. OPCODE gathers the command code. ADDR gathers address bytes. DUMMY skips filler bytes. WDATA accepts write data. RDATA streams read data. ARMED waits for a committing deselect. IGNORE discards bits. The transitions are:
- IDLE→OPCODE on select.
- OPCODE→ADDR, RDATA, WDATA, ARMED, DUMMY or IGNORE when the code byte is complete.
- ADDR→RDATA, DUMMY, ARMED or WDATA after the last address byte.
- DUMMY→RDATA after the last filler byte.
- WDATA→ARMED after the status byte.
- Any state→IDLE on deselect.

Top module: `spi_flash_frontend`

## Requirements
- R1: Bits on `si` are taken on each rising `sck` edge while `cs_n` is low, most significant bit first. The first eight bits form the command code, which appears on `cmd_op`. The codes are 0x06 write-enable, 0x04 write-disable, 0x05 status-read, 0x01 status-write, 0x03 read, 0x0B fast-read, 0xD8 sector-erase, 0xC7 array-erase, 0x02 page-program, 0xB9 power-down and 0xAB wake/signature.
- R2: Codes 0x03, 0x0B, 0xD8 and 0x02 are followed by three address bytes, high byte first. These bytes form `cmd_addr`. For every other code `cmd_addr` reads 0.
- R3: Read (0x03) raises `rd_req` when the address is complete, and again after every streamed byte. Each request carries the next address, one higher than the previous one, and 0xFFFFFF is followed by 0x000000. The byte on `rd_data` is shifted out on `so`, most significant bit first, and each bit changes only after a falling `sck` edge. Reading N bytes therefore gives N+1 requests.
- R4: Fast-read (0x0B) skips one filler byte after the address before its first request and data byte.
- R5: Status-read (0x05) streams with no address. Wake (0xAB) skips three filler bytes and then streams. Both requests carry address 0. Wake deselected after exactly eight edges issues an execute for 0xAB.
- R6: The execute strobe `exe_valid` lasts one `clk` cycle and carries `cmd_op` and `cmd_addr`. It fires after deselect only when the edge count is a nonzero multiple of eight and the command received all its bytes. Those bytes are: the code alone for 0x06/0x04/0xC7/0xB9/0xAB, three address bytes for 0xD8, at least one data byte for 0x02/0x01.
- R7: A write-type command deselected off a byte boundary produces no execute.
- R8: Page-program data bytes pulse `wr_valid` with `wr_data` and `wr_idx`. The index counts from 0 and wraps modulo 256, so the last 256 bytes land in distinct slots. Status-write passes only its first data byte.
- R9: When `busy` is high as the code byte completes, every command except status-read is ignored: no request, no write pulse, no execute.
- R10: An unknown code makes the block ignore all further bits until deselect.
- R11: After reset and while deselected `so_oe` and `so` are low. `so_oe` is high while selected.
- R12: A read cut off in the middle of a byte ends cleanly with no execute, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock, samples the pins |
| rst_n | input | 1 | asynchronous active-low reset |
| sck | input | 1 | serial clock |
| cs_n | input | 1 | active-low select |
| si | input | 1 | serial data in |
| so | output | 1 | serial data out |
| so_oe | output | 1 | output enable for `so` |
| busy | input | 1 | array controller is writing or erasing |
| cmd_op | output | 8 | current command code |
| cmd_addr | output | 24 | current address |
| exe_valid | output | 1 | execute strobe for write-type commands |
| wr_valid | output | 1 | write-data byte strobe |
| wr_idx | output | 8 | slot index of the write byte |
| wr_data | output | 8 | write-data byte |
| rd_req | output | 1 | read-byte request |
| rd_data | input | 8 | byte returned for the last request |

## Verification
Requests, write pulses and the code and address outputs are registered. They appear one `clk` after the cycle in which `clk` first sees `sck` high on the completing bit. The execute strobe appears one `clk` after `clk` first sees `cs_n` high. A new `so` bit is present one `clk` after a falling `sck` edge is seen. The memory must hold `rd_data` from a request until the next falling edge. The bench holds each `sck` level for four clocks and samples `so` just before raising `sck`. It drives pins on falling `clk` edges, and a monitor compares each strobe against queued expectations on falling `clk` edges. Each scenario ends by confirming that no expected item is left over.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_FAST = 8'h0B;
    localparam logic [7:0] OPC_SE   = 8'hD8;
    localparam logic [7:0] OPC_BE   = 8'hC7;
    localparam logic [7:0] OPC_PP   = 8'h02;
    localparam logic [7:0] OPC_DP   = 8'hB9;
    localparam logic [7:0] OPC_RES  = 8'hAB;

    localparam int FAST_FILL = 1;
    localparam int RES_FILL  = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_DUMMY,
        ST_WDATA, ST_RDATA, ST_ARMED, ST_IGNORE
    } fe_state_t;

    function automatic fe_state_t after_opcode(input logic [7:0] opc, input logic busy_i);
        fe_state_t nx;
        if (busy_i && opc != OPC_RDSR) begin
            nx = ST_IGNORE;
        end else begin
            case (opc)
                OPC_READ, OPC_FAST, OPC_SE, OPC_PP: nx = ST_ADDR;
                OPC_RDSR:                           nx = ST_RDATA;
                OPC_WRSR:                           nx = ST_WDATA;
                OPC_WREN, OPC_WRDI, OPC_BE, OPC_DP: nx = ST_ARMED;
                OPC_RES:                            nx = ST_DUMMY;
                default:                            nx = ST_IGNORE;
            endcase
        end
        return nx;
    endfunction

endpackage

// File: rtl/spi_fe_pins.sv
module spi_fe_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign cs_rise  = cs_n & ~cs_q;

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int IDX_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    si,
    input  logic                    busy,
    input  logic                    sck_rise,
    input  logic                    cs_rise,
    output logic [7:0]              op_o,
    output logic [8*ADDR_BYTES-1:0] addr_o,
    output logic                    exe_valid,
    output logic                    wr_valid,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [7:0]              wr_data,
    output logic                    rd_req
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int CNT_W  = (ADDR_BYTES > 4) ? $clog2(ADDR_BYTES) : 2;

    fe_state_t         state, state_nx;
    logic [2:0]        bitc;
    logic [CNT_W-1:0]  bcnt;
    logic [6:0]        shreg;
    logic              armed;
    logic [IDX_W-1:0]  widx;
    logic [7:0]        byte_in;
    logic              byte_done;
    logic [CNT_W-1:0]  fill_last;

    assign byte_in   = {shreg, si};
    assign byte_done = sck_rise && !cs_n && (bitc == 3'd7);
    assign fill_last = (op_o == OPC_RES) ? CNT_W'(RES_FILL - 1) : CNT_W'(FAST_FILL - 1);

    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_OPCODE;
                ST_OPCODE: if (byte_done) state_nx = after_opcode(byte_in, busy);
                ST_ADDR: begin
                    if (byte_done && bcnt == CNT_W'(ADDR_BYTES - 1)) begin
                        if (op_o == OPC_READ)      state_nx = ST_RDATA;
                        else if (op_o == OPC_FAST) state_nx = ST_DUMMY;
                        else if (op_o == OPC_SE)   state_nx = ST_ARMED;
                        else                       state_nx = ST_WDATA;
                    end
                end
                ST_DUMMY:  if (byte_done && bcnt == fill_last) state_nx = ST_RDATA;
                ST_WDATA:  if (byte_done && op_o == OPC_WRSR) state_nx = ST_ARMED;
                ST_RDATA:  state_nx = ST_RDATA;
                ST_ARMED:  state_nx = ST_ARMED;
                ST_IGNORE: state_nx = ST_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitc <= '0; bcnt <= '0; shreg <= '0; armed <= 1'b0; widx <= '0;
            op_o <= '0; addr_o <= '0; exe_valid <= 1'b0; wr_valid <= 1'b0;
            wr_idx <= '0; wr_data <= '0; rd_req <= 1'b0;
        end else begin
            exe_valid <= cs_rise && armed && (bitc == 3'd0);
            wr_valid  <= 1'b0;
            rd_req    <= 1'b0;
            if (cs_n) begin
                bitc <= '0; bcnt <= '0; shreg <= '0; armed <= 1'b0; widx <= '0;
            end else if (sck_rise) begin
                bitc  <= bitc + 3'd1;
                shreg <= byte_in[6:0];
                if (bitc == 3'd7) begin
                    unique case (state)
                        ST_OPCODE: begin
                            op_o   <= byte_in;
                            addr_o <= '0;
                            bcnt   <= '0;
                            armed  <= (state_nx == ST_ARMED) || (state_nx == ST_DUMMY);
                            rd_req <= (state_nx == ST_RDATA);
                        end
                        ST_ADDR: begin
                            addr_o <= {addr_o[ADDR_W-9:0], byte_in};
                            bcnt   <= (state_nx == ST_ADDR) ? bcnt + CNT_W'(1) : '0;
                            armed  <= (state_nx == ST_ARMED);
                            rd_req <= (state_nx == ST_RDATA);
                        end
                        ST_DUMMY: begin
                            bcnt   <= bcnt + CNT_W'(1);
                            rd_req <= (state_nx == ST_RDATA);
                        end
                        ST_WDATA: begin
                            wr_valid <= 1'b1;
                            wr_data  <= byte_in;
                            wr_idx   <= widx;
                            widx     <= widx + IDX_W'(1);
                            armed    <= 1'b1;
                        end
                        ST_RDATA: begin
                            rd_req <= 1'b1;
                            if (op_o == OPC_READ || op_o == OPC_FAST) addr_o <= addr_o + ADDR_W'(1);
                        end
                        default: ;
                    endcase
                end else if (state == ST_DUMMY && op_o == OPC_RES) begin
                    armed <= 1'b0;
                end
            end
        end
    end

    AST_EXE_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid |-> cs_n); // R6
    AST_EXE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid |=> !exe_valid); // R6
    AST_WR_ONLY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (op_o == OPC_PP || op_o == OPC_WRSR)); // R8
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!wr_valid && !rd_req)); // R10
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && cs_n) |-> (state == ST_IDLE)); // R11

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck_fall,
    input  logic       rd_req,
    input  logic [7:0] rd_data,
    output logic       so,
    output logic       so_oe
);
    logic [7:0] sreg;
    logic       pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg  <= '0;
            pend  <= 1'b0;
            so_oe <= 1'b0;
        end else begin
            so_oe <= !cs_n;
            if (cs_n) begin
                sreg <= '0;
                pend <= 1'b0;
            end else begin
                if (rd_req) pend <= 1'b1;
                if (sck_fall) begin
                    if (pend) begin
                        sreg <= rd_data;
                        pend <= 1'b0;
                    end else begin
                        sreg <= {sreg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign so = sreg[7] & so_oe;

    AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !$past(sck_fall)) |-> $stable(so)); // R3

endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend #(
    parameter int ADDR_BYTES = 3,
    parameter int IDX_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sck,
    input  logic                    cs_n,
    input  logic                    si,
    output logic                    so,
    output logic                    so_oe,
    input  logic                    busy,
    output logic [7:0]              cmd_op,
    output logic [8*ADDR_BYTES-1:0] cmd_addr,
    output logic                    exe_valid,
    output logic                    wr_valid,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [7:0]              wr_data,
    output logic                    rd_req,
    input  logic [7:0]              rd_data
);
    logic sck_rise, sck_fall, cs_rise;

    spi_fe_pins u_pins (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    spi_fe_ctrl #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .si(si), .busy(busy),
        .sck_rise(sck_rise), .cs_rise(cs_rise),
        .op_o(cmd_op), .addr_o(cmd_addr), .exe_valid(exe_valid),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .rd_req(rd_req)
    );

    spi_fe_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
        .rd_req(rd_req), .rd_data(rd_data), .so(so), .so_oe(so_oe)
    );

endmodule

// File: tb/test_spi_flash_frontend.sv
module test_spi_flash_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam logic [7:0] STATUS_VAL = 8'hA5;
    localparam logic [7:0] SIG_VAL    = 8'h12;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, busy = 1'b0;
    logic so, so_oe, exe_valid, wr_valid, rd_req;
    logic [7:0] cmd_op, wr_idx, wr_data, rd_data;
    logic [23:0] cmd_addr;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [31:0] q_exe[$], q_rd[$];
    logic [15:0] q_wr[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_frontend i_spi_flash_frontend (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
        .busy(busy), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .exe_valid(exe_valid),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
    );

    function automatic logic [7:0] model(input logic [7:0] op, input logic [23:0] a);
        if (op == 8'h05) return STATUS_VAL;
        if (op == 8'hAB) return SIG_VAL;
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    assign rd_data = model(cmd_op, cmd_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] e32;
    logic [15:0] e16;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exe_valid) begin
                if (q_exe.size() == 0) chk(1'b0, "R6 unexpected execute", {cmd_op, cmd_addr}, 32'h0);
                else begin e32 = q_exe.pop_front(); chk({cmd_op, cmd_addr} == e32, "R6 execute", {cmd_op, cmd_addr}, e32); end
            end
            if (wr_valid) begin
                if (q_wr.size() == 0) chk(1'b0, "R8 unexpected write", {16'h0, wr_idx, wr_data}, 32'h0);
                else begin e16 = q_wr.pop_front(); chk({wr_idx, wr_data} == e16, "R8 write byte", {16'h0, wr_idx, wr_data}, {16'h0, e16}); end
            end
            if (rd_req) begin
                if (q_rd.size() == 0) chk(1'b0, "R3 unexpected read request", {cmd_op, cmd_addr}, 32'h0);
                else begin e32 = q_rd.pop_front(); chk({cmd_op, cmd_addr} == e32, "R3 read request", {cmd_op, cmd_addr}, e32); end
            end
        end
    end

    task automatic bit_x(input logic b, output logic r);
        sck = 1'b0; si = b;
        repeat (HALF) @(negedge clk);
        r = so;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
    endtask

    task automatic bits(input int n, input logic [7:0] tx);
        logic r;
        for (int i = 0; i < n; i++) bit_x(tx[7-i], r);
    endtask

    task automatic sel();
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk); sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        chk(q_exe.size() == 0 && q_wr.size() == 0 && q_rd.size() == 0, tag,
            q_exe.size() + q_wr.size() + q_rd.size(), 0);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] rx;
        xfer(a[23:16], rx); xfer(a[15:8], rx); xfer(a[7:0], rx);
    endtask

    initial begin
        logic [7:0] rx;
        logic [23:0] a;
        repeat (3) @(negedge clk);
        chk(!so_oe && !so && !exe_valid && !wr_valid && !rd_req, "R11 reset state",
            {so_oe, so, exe_valid, wr_valid, rd_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R6: write-enable on a byte boundary
        q_exe.push_back({8'h06, 24'h0});
        sel(); chk(so_oe == 1'b1, "R11 output enabled while selected", so_oe, 1);
        xfer(8'h06, rx); desel();
        chk(so_oe == 1'b0, "R11 output disabled when deselected", so_oe, 0);
        drain("R1 write-enable executed");

        // R7: off-boundary deselects
        sel(); bits(7, 8'h04); desel(); drain("R7 seven-bit command dropped");
        sel(); xfer(8'h06, rx); bits(1, 8'h00); desel(); drain("R7 nine-bit command dropped");
        sel(); xfer(8'hD8, rx); send_addr(24'h123456); bits(4, 8'hF0); desel(); drain("R7 erase off boundary dropped");

        // R2 R6: sector erase complete and short
        q_exe.push_back({8'hD8, 24'h123456});
        sel(); xfer(8'hD8, rx); send_addr(24'h123456); desel(); drain("R2 erase address");
        sel(); xfer(8'hD8, rx); xfer(8'h12, rx); xfer(8'h34, rx); desel(); drain("R6 short address no execute");

        // R8: page program, then wrap past 256
        for (int k = 0; k < 3; k++) q_wr.push_back({8'(k), 8'(k) ^ 8'h55});
        q_exe.push_back({8'h02, 24'h00AB00});
        sel(); xfer(8'h02, rx); send_addr(24'h00AB00);
        for (int k = 0; k < 3; k++) xfer(8'(k) ^ 8'h55, rx);
        desel(); drain("R8 program three bytes");

        for (int k = 0; k < 258; k++) q_wr.push_back({8'(k), 8'(k * 7)});
        q_exe.push_back({8'h02, 24'h000100});
        sel(); xfer(8'h02, rx); send_addr(24'h000100);
        for (int k = 0; k < 258; k++) xfer(8'(k * 7), rx);
        desel(); drain("R8 program index wrap");

        q_wr.push_back({8'h00, 8'h9C});
        q_exe.push_back({8'h01, 24'h0});
        sel(); xfer(8'h01, rx); xfer(8'h9C, rx); xfer(8'h77, rx); desel(); drain("R8 status write one byte");

        // R3: read across the top of the address space
        a = 24'hFFFFFE;
        for (int k = 0; k < 4; k++) q_rd.push_back({8'h03, 24'(a + 24'(k))});
        sel(); xfer(8'h03, rx); send_addr(a);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, rx);
            chk(rx == model(8'h03, 24'(a + 24'(k))), "R3 read data", rx, model(8'h03, 24'(a + 24'(k))));
        end
        desel(); drain("R3 read requests");

        // R4: fast read with one filler byte
        a = 24'h000010;
        for (int k = 0; k < 3; k++) q_rd.push_back({8'h0B, 24'(a + 24'(k))});
        sel(); xfer(8'h0B, rx); send_addr(a); xfer(8'hFF, rx);
        for (int k = 0; k < 2; k++) begin
            xfer(8'h00, rx);
            chk(rx == model(8'h0B, 24'(a + 24'(k))), "R4 fast read data", rx, model(8'h0B, 24'(a + 24'(k))));
        end
        desel(); drain("R4 fast read requests");

        // R5: status read, signature read, wake
        for (int k = 0; k < 3; k++) q_rd.push_back({8'h05, 24'h0});
        sel(); xfer(8'h05, rx);
        for (int k = 0; k < 2; k++) begin
            xfer(8'h00, rx); chk(rx == STATUS_VAL, "R5 status byte", rx, STATUS_VAL);
        end
        desel(); drain("R5 status requests");

        for (int k = 0; k < 2; k++) q_rd.push_back({8'hAB, 24'h0});
        sel(); xfer(8'hAB, rx); xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h00, rx);
        xfer(8'h00, rx); chk(rx == SIG_VAL, "R5 signature byte", rx, SIG_VAL);
        desel(); drain("R5 signature no execute");

        q_exe.push_back({8'hAB, 24'h0});
        sel(); xfer(8'hAB, rx); desel(); drain("R5 wake execute");

        // R12: read cut mid-byte, then normal command
        q_rd.push_back({8'h03, 24'h000100});
        sel(); xfer(8'h03, rx); send_addr(24'h000100); bits(3, 8'h00); desel();
        drain("R12 aborted read");
        q_exe.push_back({8'h06, 24'h0});
        sel(); xfer(8'h06, rx); desel(); drain("R12 next command after abort");

        // R9: busy blocks all but status read
        busy = 1'b1;
        sel(); xfer(8'h03, rx); send_addr(24'h000200); xfer(8'h00, rx); desel(); drain("R9 read ignored while busy");
        sel(); xfer(8'h02, rx); send_addr(24'h000200); xfer(8'h11, rx); desel(); drain("R9 program ignored while busy");
        for (int k = 0; k < 2; k++) q_rd.push_back({8'h05, 24'h0});
        sel(); xfer(8'h05, rx); xfer(8'h00, rx); desel();
        chk(rx == STATUS_VAL, "R9 status read while busy", rx, STATUS_VAL);
        drain("R9 status requests while busy");
        busy = 1'b0;

        // R10: unknown code
        sel(); xfer(8'hFF, rx); xfer(8'h06, rx); xfer(8'h02, rx); desel(); drain("R10 unknown code ignored");

        repeat (10) @(negedge clk);
        drain("R6 nothing outstanding");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule